// File: doc/BRIEF.md
# Stereo Source Selector and Averager

This block decides what each of the two output channels carries before the per-channel attenuation stages. A 5-bit mixing code picks, for output A and output B independently, one of four sources: silence, the left input sample, the right input sample, or the mean of left and right. A fifth code bit exchanges the two selections, so either output can be routed from either field without rewriting the code.

Samples are signed two's complement of a parameterised width. A new left/right pair is taken whenever the input strobe is high. The chosen results are registered on that clock edge. A one-cycle output strobe then tells the following volume stages that fresh samples are present. Between strobes the outputs hold their last value. The mean is formed with one extra guard bit and an arithmetic halving, so it always lies between the two inputs and cannot wrap. The block has no sequencing states: its only storage is the output register and its strobe. A shared gain applied later acts equally on both terms of any averaged output.

Top module: `stmix_core`

## Requirements
- R1: While reset is asserted (rst_n low) and after its release until the first strobe, out_a and out_b are 0 and out_valid is 0.
- R2: The 2-bit source fields decode as 00 = mute (output 0), 01 = left sample, 10 = right sample, 11 = mean of left and right.
- R3: The mean equals floor((L+R)/2), computed with one guard bit. It never overflows: two full-scale positive inputs give full-scale positive, two full-scale negative inputs give full-scale negative, and -1 with 0 gives -1.
- R4: With mix_code[4] = 0, mix_code[3:2] selects the source of out_a and mix_code[1:0] selects the source of out_b, each independent of the other.
- R5: With mix_code[4] = 1, out_a takes the source selected by mix_code[1:0] and out_b takes the source selected by mix_code[3:2].
- R6: A sample pair and code presented with in_valid high at a rising edge appear on out_a and out_b after that edge, and out_valid is high for exactly the one following cycle.
- R7: With in_valid low, changes on in_left, in_right and mix_code have no effect: out_a and out_b keep their values and out_valid stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Strobe marking a new left/right pair |
| in_left | input | SAMPLE_W | Left input sample, signed |
| in_right | input | SAMPLE_W | Right input sample, signed |
| mix_code | input | 5 | [4] swap, [3:2] source of A, [1:0] source of B |
| out_a | output | SAMPLE_W | Mixed sample for channel A volume stage |
| out_b | output | SAMPLE_W | Mixed sample for channel B volume stage |
| out_valid | output | 1 | One-cycle strobe, fresh samples on out_a/out_b |

## Verification
The embedded assertions watch, on every cycle, that the outputs hold and the strobe stays low without an input strobe, that the output strobe follows the input strobe by one cycle, that the all-mute code yields zeros, and that an averaged output stays between the two inputs that produced it. The full source decode, the independence of the two fields, the swap bit and the exact rounding of the mean at the full-scale extremes can only be shown by the bench's scenarios. In those scenarios a behavioural model predicts each output on every clock.

// File: rtl/stmix_pkg.sv
package stmix_pkg;
    localparam int CODE_W = 5;
    localparam int SEL_W  = 2;

    typedef enum logic [SEL_W-1:0] {
        SRC_MUTE  = 2'b00,
        SRC_LEFT  = 2'b01,
        SRC_RIGHT = 2'b10,
        SRC_MEAN  = 2'b11
    } src_sel_e;
endpackage

// File: rtl/stmix_mean.sv
module stmix_mean #(
    parameter int SAMPLE_W = 24
) (
    input  logic signed [SAMPLE_W-1:0] a_in,
    input  logic signed [SAMPLE_W-1:0] b_in,
    output logic signed [SAMPLE_W-1:0] mean_out
);
    localparam int SUM_W = SAMPLE_W + 1;

    logic signed [SUM_W-1:0] sum_wide;

    // guard bit keeps the sum exact; dropping bit 0 halves toward -inf
    assign sum_wide = {a_in[SAMPLE_W-1], a_in} + {b_in[SAMPLE_W-1], b_in};
    assign mean_out = sum_wide[SUM_W-1:1];
endmodule

// File: rtl/stmix_route.sv
module stmix_route
    import stmix_pkg::*;
#(
    parameter int SAMPLE_W = 24
) (
    input  src_sel_e                   sel,
    input  logic signed [SAMPLE_W-1:0] left_in,
    input  logic signed [SAMPLE_W-1:0] right_in,
    input  logic signed [SAMPLE_W-1:0] mean_in,
    output logic signed [SAMPLE_W-1:0] mix_out
);
    always_comb begin
        unique case (sel)
            SRC_MUTE:  mix_out = '0;
            SRC_LEFT:  mix_out = left_in;
            SRC_RIGHT: mix_out = right_in;
            SRC_MEAN:  mix_out = mean_in;
            default:   mix_out = '0;
        endcase
    end
endmodule

// File: rtl/stmix_core.sv
module stmix_core
    import stmix_pkg::*;
#(
    parameter int SAMPLE_W = 24
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic signed [SAMPLE_W-1:0] in_left,
    input  logic signed [SAMPLE_W-1:0] in_right,
    input  logic [CODE_W-1:0]          mix_code,
    output logic signed [SAMPLE_W-1:0] out_a,
    output logic signed [SAMPLE_W-1:0] out_b,
    output logic                       out_valid
);
    localparam int NCH      = 2;
    localparam int SWAP_BIT = CODE_W - 1;

    logic signed [SAMPLE_W-1:0] mean_w;
    logic signed [SAMPLE_W-1:0] mix_w [NCH];
    logic [SEL_W-1:0]           field_w [NCH];

    stmix_mean #(.SAMPLE_W(SAMPLE_W)) u_mean (
        .a_in    (in_left),
        .b_in    (in_right),
        .mean_out(mean_w)
    );

    // channel 0 = A (upper field), channel 1 = B (lower field)
    assign field_w[0] = mix_code[2*SEL_W-1:SEL_W];
    assign field_w[1] = mix_code[SEL_W-1:0];

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        localparam int OTHER = NCH - 1 - ch;
        logic [SEL_W-1:0] pick;
        assign pick = mix_code[SWAP_BIT] ? field_w[OTHER] : field_w[ch];

        stmix_route #(.SAMPLE_W(SAMPLE_W)) u_route (
            .sel     (src_sel_e'(pick)),
            .left_in (in_left),
            .right_in(in_right),
            .mean_in (mean_w),
            .mix_out (mix_w[ch])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_a     <= '0;
            out_b     <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_a <= mix_w[0];
                out_b <= mix_w[1];
            end
        end
    end

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_a) && $stable(out_b) && !out_valid)); // R7

    AST_STROBE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R6

    AST_MUTE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mix_code == 5'b00000) |=> (out_a == '0 && out_b == '0)); // R2

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mix_code == 5'b01111) |=>
        ((out_a >= $past(in_left) || out_a >= $past(in_right)) &&
         (out_a <= $past(in_left) || out_a <= $past(in_right)))); // R3

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_a == '0 && out_b == '0)); // R1
endmodule

// File: tb/stmix_core_test.sv
`timescale 1ns/1ps
module stmix_core_test;
    localparam int W = 24;
    localparam int MAXP = (1 << (W-1)) - 1;
    localparam int MINN = -(1 << (W-1));

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic signed [W-1:0] in_left = '0;
    logic signed [W-1:0] in_right = '0;
    logic [4:0] mix_code = '0;
    logic signed [W-1:0] out_a, out_b;
    logic out_valid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    integer exp_a = 0, exp_b = 0;
    bit exp_v = 1'b0;

    always #2.5 clk = ~clk;

    stmix_core #(.SAMPLE_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_left(in_left), .in_right(in_right), .mix_code(mix_code),
        .out_a(out_a), .out_b(out_b), .out_valid(out_valid)
    );

    function automatic integer pick_src(input logic [1:0] f, input integer l, input integer r);
        integer s;
        case (f)
            2'd0: return 0;
            2'd1: return l;
            2'd2: return r;
            default: begin
                s = l + r;
                return s >>> 1;
            end
        endcase
    endfunction

    function automatic integer ref_out(input logic [4:0] c, input integer l, input integer r, input bit chan_b);
        logic [1:0] f;
        if (c[4] ^ chan_b) f = c[1:0];
        else               f = c[3:2];
        return pick_src(f, l, r);
    endfunction

    task automatic check(input string req, input integer act, input integer exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // behavioural reference, advanced on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            exp_a = 0; exp_b = 0; exp_v = 1'b0;
        end else begin
            exp_v = in_valid;
            if (in_valid) begin
                exp_a = ref_out(mix_code, integer'(in_left), integer'(in_right), 1'b0);
                exp_b = ref_out(mix_code, integer'(in_left), integer'(in_right), 1'b1);
            end
        end
    end

    // per-cycle comparison against the model (R7 hold, R6 strobe)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R7 model out_a", integer'(out_a), exp_a);
            check("R7 model out_b", integer'(out_b), exp_b);
            check("R6 model out_valid", integer'(out_valid), integer'(exp_v));
        end
    end

    task automatic push(input integer l, input integer r, input logic [4:0] c);
        @(negedge clk);
        in_left = l[W-1:0]; in_right = r[W-1:0]; mix_code = c; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic expect_pair(input string req, input integer ea, input integer eb);
        check(req, integer'(out_a), ea);
        check(req, integer'(out_b), eb);
        check({req, " strobe"}, integer'(out_valid), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset out_a", integer'(out_a), 0);
        check("R1 reset out_b", integer'(out_b), 0);
        check("R1 reset out_valid", integer'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release out_valid", integer'(out_valid), 0);
        check("R1 after release out_a", integer'(out_a), 0);

        push(1000, -2000, 5'b00101); expect_pair("R2 left both", 1000, 1000);
        push(1000, -2000, 5'b01010); expect_pair("R2 right both", -2000, -2000);
        push(1000, -2000, 5'b00000); expect_pair("R2 mute both", 0, 0);
        push(1001, 2000, 5'b01111); expect_pair("R2 mean both", 1500, 1500);

        push(MAXP, MAXP, 5'b01111); expect_pair("R3 full positive", MAXP, MAXP);
        push(MINN, MINN, 5'b01111); expect_pair("R3 full negative", MINN, MINN);
        push(-1, 0, 5'b01111);      expect_pair("R3 floor rounding", -1, -1);
        push(MAXP, MINN, 5'b01111); expect_pair("R3 opposite extremes", -1, -1);

        push(77, -55, 5'b00110); expect_pair("R4 A left B right", 77, -55);
        push(77, -55, 5'b01100); expect_pair("R4 A mean B mute", 11, 0);
        push(77, -55, 5'b10110); expect_pair("R5 swap", -55, 77);
        push(77, -55, 5'b11100); expect_pair("R5 swap mean", 0, 11);

        @(negedge clk);
        check("R6 strobe single cycle", integer'(out_valid), 0);

        // change everything without a strobe
        in_left = 24'sd12345; in_right = -24'sd999; mix_code = 5'b00101;
        repeat (3) @(negedge clk);
        check("R7 hold out_a", integer'(out_a), 0);
        check("R7 hold out_b", integer'(out_b), 11);
        check("R7 hold out_valid", integer'(out_valid), 0);

        push(300, 100, 5'b11011); expect_pair("R5 swap right/mean", 200, 100);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule